// File: doc/BRIEF.md
# Dual-Channel Receive Sample Buffer

This block stores incoming serial-port samples for two independent channels, an audio channel and a telecom channel. Each channel has its own 12-entry receive queue. A frame deserializer sits upstream. For each sample it presents a one-cycle valid strobe with the raw bits. The block left-justifies the sample into a 16-bit word, filling the low bits with zeros, and appends the word to that channel's queue. Software or a DMA engine drains each queue through a pop strobe. The popped word appears on a registered read-data port.

Each channel raises a service request while its occupancy is at or above a trigger depth. A shared 2-bit setting picks that depth from the window 5 to 8. This reproduces the uncertain trigger point of a self-timed buffer. A request therefore always leaves at least four samples available. Per channel, the block reports occupancy, not-empty and full. It also keeps sticky overrun and underrun flags, each cleared by a write-one strobe.

Top module: `rxq_unit`

## Requirements
- R1: An audio sample of 12 bits is stored as word bits 15:4, and word bits 3:0 read as zero.
- R2: A telecom sample of 14 bits is stored as word bits 15:2, and word bits 1:0 read as zero.
- R3: Each queue holds up to 12 words. Words come out in the order they went in, and the word appears on the read-data port one clock after the pop strobe.
- R4: The trigger depth is 5 + trig_sel, so the codes 0, 1, 2 and 3 select 5, 6, 7 and 8. A channel's request is high when its occupancy is at least the trigger depth.
- R5: The request drops in the same cycle that the occupancy falls below the trigger depth.
- R6: A sample strobed into a full queue is discarded, and the occupancy stays at 12. The sticky overrun flag sets on the next clock and stays set until a one is written to the channel's overrun-clear input.
- R7: A pop of an empty queue returns 0x0000 on read data and sets the sticky underrun flag. The underrun flag stays set until a one is written to the channel's underrun-clear input.
- R8: The occupancy output gives the number of stored words. Not-empty is high when occupancy is nonzero, and full is high when occupancy equals 12. All three update one clock after a push or a pop.
- R9: Activity on one channel never changes the occupancy, data or flags of the other channel.
- R10: After reset, both queues are empty. All requests, flags and read data are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_sel | input | 2 | Trigger depth select (depth = 5 + value) |
| aud_vld | input | 1 | Audio sample strobe |
| aud_smp | input | 12 | Raw audio sample |
| tel_vld | input | 1 | Telecom sample strobe |
| tel_smp | input | 14 | Raw telecom sample |
| aud_pop | input | 1 | Pop one audio word |
| tel_pop | input | 1 | Pop one telecom word |
| aud_ovr_clr | input | 1 | Write-one clear of audio overrun |
| tel_ovr_clr | input | 1 | Write-one clear of telecom overrun |
| aud_und_clr | input | 1 | Write-one clear of audio underrun |
| tel_und_clr | input | 1 | Write-one clear of telecom underrun |
| aud_rdata | output | 16 | Last popped audio word |
| tel_rdata | output | 16 | Last popped telecom word |
| aud_cnt | output | 4 | Audio occupancy |
| tel_cnt | output | 4 | Telecom occupancy |
| aud_nempty | output | 1 | Audio queue not empty |
| tel_nempty | output | 1 | Telecom queue not empty |
| aud_full | output | 1 | Audio queue full |
| tel_full | output | 1 | Telecom queue full |
| aud_req | output | 1 | Audio service request |
| tel_req | output | 1 | Telecom service request |
| aud_ovr | output | 1 | Audio sticky overrun |
| tel_ovr | output | 1 | Telecom sticky overrun |
| aud_und | output | 1 | Audio sticky underrun |
| tel_und | output | 1 | Telecom sticky underrun |

## Verification
The hardest corner to reach is the overrun path. The queue must be full when the extra sample arrives, and the dropped word must never show up later in the read sequence. The stimulus fills the audio queue to exactly 12 words and strobes one more distinctive sample. The bench then clears the flag and drains every entry through the scoreboard. Any leaked word would appear as a mismatch or as an extra entry.

The request window is covered a different way. For each of the four trigger codes, the bench fills a queue one sample at a time and then drains it. This walks the occupancy across the threshold in both directions, once per setting.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  parameter int unsigned WORD_W    = 16;
  parameter int unsigned AUD_W     = 12;
  parameter int unsigned TEL_W     = 14;
  parameter int unsigned DEPTH     = 12;
  parameter int unsigned TRIG_BASE = 5;
  parameter int unsigned SEL_W     = 2;
  localparam int unsigned CNT_W    = $clog2(DEPTH + 1);

  // Trigger threshold for a select code.
  function automatic logic [CNT_W-1:0] trig_depth(input logic [SEL_W-1:0] sel);
    return CNT_W'(TRIG_BASE) + CNT_W'(sel);
  endfunction

  // Wrap-around increment of a queue index.
  function automatic logic [CNT_W-1:0] ptr_next(input logic [CNT_W-1:0] p);
    return (p == CNT_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction
endpackage

// File: rtl/rxq_align.sv
module rxq_align #(
  parameter int unsigned SMP_W  = 12,
  parameter int unsigned WORD_W = 16
) (
  input  logic [SMP_W-1:0]  smp,
  output logic [WORD_W-1:0] word
);
  localparam int unsigned PAD_W = WORD_W - SMP_W;

  generate
    if (PAD_W == 0) begin : g_full
      assign word = smp;
    end else begin : g_pad
      assign word = {smp, {PAD_W{1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo
  import rxq_pkg::*;
#(
  parameter int unsigned W = WORD_W,
  parameter int unsigned D = DEPTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     wdata,
  input  logic             pop,
  output logic [W-1:0]     rdata,
  output logic [CNT_W-1:0] cnt,
  output logic             push_drop,
  output logic             pop_miss
);
  logic [W-1:0]     mem [D];
  logic [CNT_W-1:0] wr_ptr, rd_ptr;
  logic             is_full, is_empty, push_ok, pop_ok;

  assign is_full   = (cnt == CNT_W'(D));
  assign is_empty  = (cnt == '0);
  assign push_ok   = push && !is_full;
  assign pop_ok    = pop && !is_empty;
  assign push_drop = push && is_full;
  assign pop_miss  = pop && is_empty;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      rdata  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_next(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
      if (pop)     rdata  <= pop_ok ? mem[rd_ptr] : '0;
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/rxq_chan.sv
module rxq_chan
  import rxq_pkg::*;
#(
  parameter int unsigned SMP_W = AUD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  trig_sel,
  input  logic              vld,
  input  logic [SMP_W-1:0]  smp,
  input  logic              pop,
  input  logic              ovr_clr,
  input  logic              und_clr,
  output logic [WORD_W-1:0] rdata,
  output logic [CNT_W-1:0]  cnt,
  output logic              nempty,
  output logic              full,
  output logic              req,
  output logic              ovr,
  output logic              und
);
  logic [WORD_W-1:0] word;
  logic              push_drop, pop_miss;
  logic [CNT_W-1:0]  thresh;

  rxq_align #(.SMP_W(SMP_W), .WORD_W(WORD_W)) align_i (
    .smp  (smp),
    .word (word)
  );

  rxq_fifo #(.W(WORD_W), .D(DEPTH)) fifo_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (vld),
    .wdata     (word),
    .pop       (pop),
    .rdata     (rdata),
    .cnt       (cnt),
    .push_drop (push_drop),
    .pop_miss  (pop_miss)
  );

  assign thresh = trig_depth(trig_sel);
  assign req    = (cnt >= thresh);
  assign nempty = (cnt != '0);
  assign full   = (cnt == CNT_W'(DEPTH));

  // Sticky flags: a new event wins over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovr <= 1'b0;
      und <= 1'b0;
    end else begin
      if (push_drop)    ovr <= 1'b1;
      else if (ovr_clr) ovr <= 1'b0;
      if (pop_miss)     und <= 1'b1;
      else if (und_clr) und <= 1'b0;
    end
  end
endmodule

// File: rtl/rxq_unit.sv
module rxq_unit
  import rxq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  trig_sel,
  input  logic        aud_vld,
  input  logic [11:0] aud_smp,
  input  logic        tel_vld,
  input  logic [13:0] tel_smp,
  input  logic        aud_pop,
  input  logic        tel_pop,
  input  logic        aud_ovr_clr,
  input  logic        tel_ovr_clr,
  input  logic        aud_und_clr,
  input  logic        tel_und_clr,
  output logic [15:0] aud_rdata,
  output logic [15:0] tel_rdata,
  output logic [3:0]  aud_cnt,
  output logic [3:0]  tel_cnt,
  output logic        aud_nempty,
  output logic        tel_nempty,
  output logic        aud_full,
  output logic        tel_full,
  output logic        aud_req,
  output logic        tel_req,
  output logic        aud_ovr,
  output logic        tel_ovr,
  output logic        aud_und,
  output logic        tel_und
);
  rxq_chan #(.SMP_W(AUD_W)) aud_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_sel (trig_sel),
    .vld      (aud_vld),
    .smp      (aud_smp),
    .pop      (aud_pop),
    .ovr_clr  (aud_ovr_clr),
    .und_clr  (aud_und_clr),
    .rdata    (aud_rdata),
    .cnt      (aud_cnt),
    .nempty   (aud_nempty),
    .full     (aud_full),
    .req      (aud_req),
    .ovr      (aud_ovr),
    .und      (aud_und)
  );

  rxq_chan #(.SMP_W(TEL_W)) tel_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_sel (trig_sel),
    .vld      (tel_vld),
    .smp      (tel_smp),
    .pop      (tel_pop),
    .ovr_clr  (tel_ovr_clr),
    .und_clr  (tel_und_clr),
    .rdata    (tel_rdata),
    .cnt      (tel_cnt),
    .nempty   (tel_nempty),
    .full     (tel_full),
    .req      (tel_req),
    .ovr      (tel_ovr),
    .und      (tel_und)
  );
endmodule

// File: rtl/rxq_unit_chk.sv
module rxq_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  trig_sel,
  input logic        aud_vld,
  input logic        tel_vld,
  input logic        aud_pop,
  input logic        tel_pop,
  input logic [15:0] aud_rdata,
  input logic [15:0] tel_rdata,
  input logic [3:0]  aud_cnt,
  input logic [3:0]  tel_cnt,
  input logic        aud_nempty,
  input logic        aud_full,
  input logic        aud_req,
  input logic        tel_req,
  input logic        aud_ovr,
  input logic        aud_und
);
  logic [3:0] lim;
  assign lim = 4'd5 + {2'b00, trig_sel};

  AST_AUD_PAD: assert property (@(posedge clk) disable iff (!rst_n) aud_rdata[3:0] == 4'h0); // R1
  AST_TEL_PAD: assert property (@(posedge clk) disable iff (!rst_n) tel_rdata[1:0] == 2'h0); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) aud_cnt <= 4'd12 && tel_cnt <= 4'd12); // R3
  AST_REQ_DEPTH: assert property (@(posedge clk) disable iff (!rst_n) aud_req |-> aud_cnt >= lim); // R4
  AST_REQ_LOW: assert property (@(posedge clk) disable iff (!rst_n) aud_cnt < 4'd5 |-> !aud_req && !(tel_cnt < 4'd5 && tel_req)); // R5
  AST_DROP_FULL: assert property (@(posedge clk) disable iff (!rst_n) aud_vld && aud_full && !aud_pop |=> aud_cnt == 4'd12 && aud_ovr); // R6
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n) aud_pop && !aud_nempty |=> aud_und && aud_rdata == 16'h0); // R7
  AST_FULL_FLAG: assert property (@(posedge clk) disable iff (!rst_n) aud_full |-> aud_cnt == 4'd12); // R8
  AST_ISOLATE: assert property (@(posedge clk) disable iff (!rst_n) aud_vld && !tel_vld && !tel_pop |=> $stable(tel_cnt)); // R9
endmodule

bind rxq_unit rxq_unit_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .trig_sel   (trig_sel),
  .aud_vld    (aud_vld),
  .tel_vld    (tel_vld),
  .aud_pop    (aud_pop),
  .tel_pop    (tel_pop),
  .aud_rdata  (aud_rdata),
  .tel_rdata  (tel_rdata),
  .aud_cnt    (aud_cnt),
  .tel_cnt    (tel_cnt),
  .aud_nempty (aud_nempty),
  .aud_full   (aud_full),
  .aud_req    (aud_req),
  .tel_req    (tel_req),
  .aud_ovr    (aud_ovr),
  .aud_und    (aud_und)
);

// File: tb/rxq_unit_tb_top.sv
module rxq_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  trig_sel = '0;
  logic        aud_vld = 0, tel_vld = 0, aud_pop = 0, tel_pop = 0;
  logic [11:0] aud_smp = '0;
  logic [13:0] tel_smp = '0;
  logic        aud_ovr_clr = 0, tel_ovr_clr = 0, aud_und_clr = 0, tel_und_clr = 0;
  logic [15:0] aud_rdata, tel_rdata;
  logic [3:0]  aud_cnt, tel_cnt;
  logic        aud_nempty, tel_nempty, aud_full, tel_full;
  logic        aud_req, tel_req, aud_ovr, tel_ovr, aud_und, tel_und;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] q_aud[$];
  logic [15:0] q_tel[$];

  always #5 clk = ~clk;

  rxq_unit dut_i (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Driver: strobe a sample and record the expected word.
  task automatic push_aud(input logic [11:0] s);
    @(negedge clk);
    aud_vld = 1; aud_smp = s;
    if (q_aud.size() < 12) q_aud.push_back({s, 4'h0});
    @(negedge clk);
    aud_vld = 0;
  endtask

  task automatic push_tel(input logic [13:0] s);
    @(negedge clk);
    tel_vld = 1; tel_smp = s;
    if (q_tel.size() < 12) q_tel.push_back({s, 2'b00});
    @(negedge clk);
    tel_vld = 0;
  endtask

  task automatic pop_aud();
    @(negedge clk); aud_pop = 1;
    @(negedge clk); aud_pop = 0;
  endtask

  task automatic pop_tel();
    @(negedge clk); tel_pop = 1;
    @(negedge clk); tel_pop = 0;
  endtask

  // Monitor: compare each popped word with the scoreboard.
  always @(posedge clk) begin
    if (aud_pop) begin
      logic [15:0] e;
      bit emp;
      emp = (q_aud.size() == 0);
      e = emp ? 16'h0 : q_aud.pop_front();
      #1;
      chk(aud_rdata == e, emp ? "R7 audio empty pop" : "R1/R3 audio word", aud_rdata, e);
      if (emp) chk(aud_und == 1, "R7 audio underrun", aud_und, 1);
    end
    if (tel_pop) begin
      logic [15:0] e;
      bit emp;
      emp = (q_tel.size() == 0);
      e = emp ? 16'h0 : q_tel.pop_front();
      #1;
      chk(tel_rdata == e, emp ? "R7 telecom empty pop" : "R2/R3 telecom word", tel_rdata, e);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk(aud_cnt == 0 && tel_cnt == 0, "R10 counts", {aud_cnt, tel_cnt}, 0);
    chk(!aud_nempty && !tel_nempty && !aud_full && !tel_full, "R10 status", 1, 0);
    chk(!aud_req && !tel_req && !aud_ovr && !tel_ovr && !aud_und && !tel_und, "R10 flags", 1, 0);
    chk(aud_rdata == 0 && tel_rdata == 0, "R10 rdata", aud_rdata, 0);

    // R4/R5/R8 sweep every trigger code
    for (int sel = 0; sel < 4; sel++) begin
      trig_sel = 2'(sel);
      for (int i = 1; i <= 9; i++) begin
        push_aud(12'(i * 293 + sel));
        chk(aud_cnt == 4'(i), "R8 audio count", aud_cnt, i);
        chk(aud_nempty == 1, "R8 not-empty", aud_nempty, 1);
        chk(aud_req == (i >= 5 + sel), "R4 audio request", aud_req, i >= 5 + sel);
        chk(tel_cnt == 0 && !tel_req, "R9 telecom idle", tel_cnt, 0);
      end
      for (int i = 9; i >= 1; i--) begin
        pop_aud();
        chk(aud_req == (i - 1 >= 5 + sel), "R5 audio request drop", aud_req, i - 1 >= 5 + sel);
      end
      chk(!aud_nempty, "R8 audio empty", aud_nempty, 0);
      for (int i = 1; i <= 9; i++) begin
        push_tel(14'(i * 1871 + sel));
        chk(tel_req == (i >= 5 + sel), "R4 telecom request", tel_req, i >= 5 + sel);
      end
      for (int i = 9; i >= 1; i--) begin
        pop_tel();
        chk(tel_req == (i - 1 >= 5 + sel), "R5 telecom request drop", tel_req, i - 1 >= 5 + sel);
      end
    end

    // R1/R2 extreme patterns
    push_aud(12'hFFF); pop_aud();
    push_tel(14'h3FFF); pop_tel();
    push_aud(12'h801); pop_aud();
    push_tel(14'h2001); pop_tel();

    // R6 overrun: fill 12, push extra
    for (int i = 0; i < 12; i++) push_aud(12'(12'h100 + i * 7));
    chk(aud_full && aud_cnt == 12, "R8 audio full", aud_cnt, 12);
    chk(!aud_ovr, "R6 no overrun yet", aud_ovr, 0);
    push_aud(12'hABC);
    chk(aud_cnt == 12, "R6 count held", aud_cnt, 12);
    chk(aud_ovr == 1, "R6 overrun set", aud_ovr, 1);
    chk(!tel_ovr && tel_cnt == 0, "R9 telecom untouched", tel_ovr, 0);
    repeat (3) @(negedge clk);
    chk(aud_ovr == 1, "R6 overrun sticky", aud_ovr, 1);
    aud_ovr_clr = 1; @(negedge clk); aud_ovr_clr = 0;
    chk(aud_ovr == 0, "R6 overrun cleared", aud_ovr, 0);
    for (int i = 0; i < 12; i++) pop_aud();
    chk(!aud_nempty && aud_cnt == 0, "R3 drained after 12", aud_cnt, 0);

    // R7 underrun
    pop_aud();
    repeat (2) @(negedge clk);
    chk(aud_und == 1, "R7 underrun sticky", aud_und, 1);
    chk(!tel_und, "R9 telecom underrun clear", tel_und, 0);
    aud_und_clr = 1; @(negedge clk); aud_und_clr = 0;
    chk(aud_und == 0, "R7 underrun cleared", aud_und, 0);
    pop_tel();
    chk(tel_und == 1, "R7 telecom underrun", tel_und, 1);
    tel_und_clr = 1; @(negedge clk); tel_und_clr = 0;
    chk(tel_und == 0, "R7 telecom underrun cleared", tel_und, 0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule